// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Ordering

This block produces the effective address for a four-beat burst memory access. When either of two address strobes is seen on a rising clock edge, it captures a base address and the ordering mode, and from the following cycle it drives that base address unchanged. Each later cycle with the advance input high and no strobe moves the burst to the next beat. A cycle with advance low holds the current beat, which suspends the burst.

The upper address bits always come from the captured base. The lowest two bits come from a two-bit beat count combined with the two captured start bits. Interleaved mode combines them with an exclusive-or. Linear mode adds them modulo four. After four advances the beat count returns to zero, so the address wraps back to the starting beat.

A small state machine tracks whether a base has been captured. It has two states. ST_IDLE is entered at reset, and in it the output stays at zero and advance pulses are ignored. ST_BURST is entered on the first strobe (transition T_START: ST_IDLE to ST_BURST). It stays in ST_BURST on every later cycle (T_HOLD, and T_RELOAD when a strobe is seen). Only reset returns it to ST_IDLE (T_RESET). The output address is derived combinationally from registers, so it changes exactly one clock edge after the input that caused the change.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and directly after it, addr_out is 0 and burst_active is 0.
- R2: On an edge where strobe_a or strobe_b (or both) is 1, the base address and mode are captured. From the next cycle addr_out equals the captured addr_in and burst_active is 1.
- R3: A strobe takes priority over advance: on an edge with both a strobe and advance high, the beat count restarts at 0 instead of stepping.
- R4: On an edge with advance = 1, no strobe and burst_active = 1, the beat count steps by one modulo 4.
- R5: On an edge with advance = 0 and no strobe, addr_out keeps its value (burst suspend).
- R6: With linear_mode = 0 captured (interleaved), addr_out[1:0] equals start[1:0] XOR beat.
- R7: With linear_mode = 1 captured (linear), addr_out[1:0] equals (start[1:0] + beat) mod 4.
- R8: During a burst, addr_out[AW-1:2] equals the captured base bits until the next strobe.
- R9: After four advances the address returns to the captured start address.
- R10: The ordering mode is sampled only at a strobe edge; changing linear_mode during a burst has no effect on addr_out.
- R11: In ST_IDLE, advance pulses have no effect: addr_out stays 0 and burst_active stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a | input | 1 | First address strobe; captures a new base |
| strobe_b | input | 1 | Second address strobe; same effect as strobe_a |
| advance | input | 1 | Step to the next beat when no strobe is present |
| linear_mode | input | 1 | 1 = linear order, 0 = interleaved order; sampled at a strobe |
| addr_in | input | AW | Base address presented with a strobe |
| addr_out | output | AW | Effective burst address |
| burst_active | output | 1 | 1 once a base has been captured since reset |

## Verification
The assertions assume that strobe_a, strobe_b, advance, linear_mode and addr_in carry known values at every rising edge once reset is released, and that none of them changes close to that edge. The stimulus changes every input one time unit after a rising edge. Inputs are never left undriven after time zero, so every edge samples a settled value. No other restriction applies: strobe, advance and mode combinations are all legal, including both strobes together and advance in the idle state.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Width of the beat counter; a burst has 2**CNT_W beats
    localparam int CNT_W = 2;
    localparam int BEATS = 1 << CNT_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } order_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strobe_a,
    input  logic   strobe_b,
    input  logic   advance,
    input  logic   mode_in,
    output logic   load,
    output logic   step,
    output logic   active,
    output order_t order_q
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        load = strobe_a | strobe_b;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_BURST;   // T_START
            ST_BURST: state_d = ST_BURST;             // T_HOLD / T_RELOAD
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;                       // T_RESET
            order_q <= ORD_INTERLEAVED;
        end else begin
            state_q <= state_d;
            if (load) order_q <= order_t'(mode_in);
        end
    end

    // outputs
    always_comb begin
        active = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin
                active = 1'b0;
                step   = 1'b0;
            end
            ST_BURST: begin
                active = 1'b1;
                step   = advance & ~load;
            end
            default:  begin
                active = 1'b0;
                step   = 1'b0;
            end
        endcase
    end

    // R10: order changes only on a strobe edge
    a_r10_order_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));

    // R11: an idle controller never requests a step
    a_r11_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !step);

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] beat
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (load) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + CNT_W'(1);
        end
    end

    // R3: a strobe restarts the beat count
    a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> beat == '0);

    // R4: a step moves exactly one beat, wrapping modulo the burst length
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> beat == $past(beat) + CNT_W'(1));

    // R5: no strobe and no step keeps the beat
    a_r5_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(beat));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  order_t           order,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low_addr
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    always_comb begin
        lin_low = start + beat;
        ilv_low = start ^ beat;
    end

    always_comb begin
        unique case (order)
            ORD_LINEAR:      low_addr = lin_low;
            ORD_INTERLEAVED: low_addr = ilv_low;
            default:         low_addr = ilv_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_a,
    input  logic          strobe_b,
    input  logic          advance,
    input  logic          linear_mode,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic          burst_active
);

    localparam int HI_W = AW - CNT_W;

    logic             load;
    logic             step;
    order_t           order_q;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] low_addr;
    logic [AW-1:0]    base_q;

    burst_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_a (strobe_a),
        .strobe_b (strobe_b),
        .advance  (advance),
        .mode_in  (linear_mode),
        .load     (load),
        .step     (step),
        .active   (burst_active),
        .order_q  (order_q)
    );

    burst_beat_cnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .beat  (beat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
        end
    end

    burst_order_map u_map (
        .order    (order_q),
        .start    (base_q[CNT_W-1:0]),
        .beat     (beat),
        .low_addr (low_addr)
    );

    always_comb begin
        addr_out = {base_q[AW-1:CNT_W], low_addr};
    end

    // R2: a strobe presents the captured address on the next cycle
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)) && burst_active);

    // R8: upper bits unchanged between strobes
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[AW-1:CNT_W]));

    // R11: without a strobe, an idle block keeps a zero address
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && !load) |=> (addr_out == '0) && !burst_active);

    initial begin
        a_r8_width_ok: assert (HI_W >= 1);
    end

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int  AW     = 8;
    localparam time CLK_PERIOD = 10;
    localparam int  NVEC   = 14;

    // fields: [20]sa [19]sb [18]adv [17]lin [16:9]addr_in [8:1]exp_addr [0]exp_active
    localparam logic [20:0] VEC [NVEC] = '{
        {4'b1000, 8'h5A, 8'h5A, 1'b1},  // R2 load via strobe_a, interleaved, start 2
        {4'b0010, 8'h00, 8'h5B, 1'b1},  // R6 beat1 2^1=3
        {4'b0000, 8'h00, 8'h5B, 1'b1},  // R5 suspend
        {4'b0010, 8'h00, 8'h58, 1'b1},  // R6 beat2 2^2=0
        {4'b0010, 8'h00, 8'h59, 1'b1},  // R6 beat3 2^3=1
        {4'b0010, 8'h00, 8'h5A, 1'b1},  // R9 wrap to start
        {4'b0111, 8'h37, 8'h37, 1'b1},  // R3 strobe_b + advance, linear, start 3
        {4'b0010, 8'h00, 8'h34, 1'b1},  // R10 mode change ignored, R7 3+1=0
        {4'b0011, 8'h00, 8'h35, 1'b1},  // R7 beat2 3+2=1
        {4'b0000, 8'h00, 8'h35, 1'b1},  // R5 suspend
        {4'b0010, 8'h00, 8'h36, 1'b1},  // R7 beat3 3+3=2
        {4'b0010, 8'h00, 8'h37, 1'b1},  // R9 wrap
        {4'b1100, 8'hC1, 8'hC1, 1'b1},  // R2 both strobes, interleaved
        {4'b0010, 8'h00, 8'hC0, 1'b1}   // R6 1^1=0, R8 upper C0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_a = 1'b0;
    logic          strobe_b = 1'b0;
    logic          advance = 1'b0;
    logic          linear_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .advance      (advance),
        .linear_mode  (linear_mode),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_v);
        n_checks++;
        if (addr_out !== exp_a || burst_active !== exp_v) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h active=%b expected addr_out=%h active=%b",
                     req, addr_out, burst_active, exp_a, exp_v);
        end
    endtask

    // drive inputs just after an edge, let the next edge take them, sample after it
    task automatic cycle(input logic sa, input logic sb, input logic adv,
                         input logic lin, input logic [AW-1:0] a);
        strobe_a    = sa;
        strobe_b    = sb;
        advance     = adv;
        linear_mode = lin;
        addr_in     = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b,
                                           input logic lin);
        return lin ? 2'((int'(s) + int'(b)) % 4) : (s ^ b);
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
        check("R1 in reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R1 after reset", 8'h00, 1'b0);

        // R11: advance in idle ignored
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b0, 1'b1, k[0], 8'hA5);
            check("R11 idle advance", 8'h00, 1'b0);
        end

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
            check($sformatf("R2-table vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // all start offsets in both modes, with a suspend and a wrap (R6 R7 R9 R5 R8)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] base;
                base = {6'h2A, 2'(s)};
                cycle(s[0], ~s[0], 1'b0, m[0], base);
                check("R2 sweep load", base, 1'b1);
                for (int b = 1; b <= 4; b++) begin
                    cycle(1'b0, 1'b0, 1'b1, ~m[0], 8'h00);
                    check(m[0] ? "R7 linear sweep" : "R6 interleaved sweep",
                          {6'h2A, exp_low(2'(s), 2'(b), m[0])}, 1'b1);
                    if (b == 2) begin
                        cycle(1'b0, 1'b0, 1'b0, m[0], 8'h00);
                        check("R5 sweep suspend",
                              {6'h2A, exp_low(2'(s), 2'(b), m[0])}, 1'b1);
                    end
                end
                check("R9 sweep wrap", base, 1'b1);
            end
        end

        // R3: strobe with advance mid-burst restarts at beat 0
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 8'h91);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R7 pre-reload", 8'h92, 1'b1);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h6E);
        check("R3 reload wins over advance", 8'h6E, 1'b1);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R10 mode held interleaved", 8'h6F, 1'b1);

        // R1: reset mid-burst returns to idle
        rst_n = 1'b0;
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        rst_n = 1'b1;
        check("R1 reset mid-burst", 8'h00, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule